// File: doc/BRIEF.md
# Hierarchical Predecoded Row Decoder

This block turns an address of `ADDR_W` bits (4 to 9) into a set of `2^ADDR_W` active-high row selects, as used in front of a memory array's wordlines. It does not decode the address as one wide value. It cuts the address into small fields. Each field is fully decoded by its own predecoder, which is either 2-to-4 or 3-to-8. The row stage then picks one predecoded line from every field, combines the picks in a NAND, and follows the NAND with an inverter. The result is that each row sees only two or three wires, and no row sees the whole address.

The mix of predecoders is fixed by the address width. Fields are taken from the low address bits upward, with every 2-bit field placed before any 3-bit field. The row numbering treats the field on the lowest address bits as the most significant digit. The row order is therefore a permutation of a plain binary decoder's order. The software or array that uses the block must expect that order.

The block is purely combinational. There is no state, so the house state-machine layout reduces here to a generate-built datapath. A global enable `row_en` gates every row. When it is held high, the outputs are strictly one-hot.

Top module: `hdec_row_decoder`

## Requirements
- R1: Every address width from 4 to 9 elaborates and decodes; address 0 selects row 0 and the all-ones address selects the last row; a width outside 4..9 stops elaboration with an error.
- R2: The predecoder mix, as (2-to-4 count, 3-to-8 count), is 4:(2,0), 5:(1,1), 6:(3,0), 7:(2,1), 8:(1,2), 9:(0,3), giving two fields for widths 4 and 5 and three fields otherwise.
- R3: Fields take address bits in ascending order. The 2-bit fields start at bit 0 and take consecutive bit pairs. The 3-bit fields follow and take consecutive bit triples.
- R4: Within a field, the field value is read in binary with the field's lowest address bit as its LSB, and predecoded line m of that field is high exactly when the field value is m.
- R5: With two fields, address field values i (field 0) and j (field 1) select row i*S1 + j, where S1 is the line count of field 1.
- R6: With three fields, field values i, j and k select row i*S1*S2 + j*S2 + k, where S1 and S2 are the line counts of fields 1 and 2.
- R7: With `row_en` high, exactly one bit of `row_sel` is high for every address.
- R8: With `row_en` low, every bit of `row_sel` is low whatever the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| row_en | input | 1 | Global enable; low forces all row selects low |
| addr | input | ADDR_W | Row address |
| row_sel | output | 2^ADDR_W | Active-high row selects in permuted order |

## Verification
A fault in field boundaries, in the field order or in a digit weight shows at the ports as soon as the address is applied. The wrong row goes high, because the block has no registers to hide or delay the error. Some slips only swap rows for certain address bits. For that reason every address of every width is swept against an independent model of the index formula. Directed addresses that set a single bit inside one field expose each field's weight on its own.

// File: rtl/hdec_pkg.sv
package hdec_pkg;

    function automatic int num_pair_fields(input int aw);
        case (aw)
            4: return 2;
            5: return 1;
            6: return 3;
            7: return 2;
            8: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int num_triple_fields(input int aw);
        case (aw)
            5: return 1;
            7: return 1;
            8: return 2;
            9: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic int num_fields(input int aw);
        return num_pair_fields(aw) + num_triple_fields(aw);
    endfunction

    function automatic int field_bits(input int aw, input int g);
        return (g < num_pair_fields(aw)) ? 2 : 3;
    endfunction

    function automatic int field_lines(input int aw, input int g);
        return 1 << field_bits(aw, g);
    endfunction

    function automatic int field_lsb(input int aw, input int g);
        int np;
        np = num_pair_fields(aw);
        return (g < np) ? 2 * g : 2 * np + 3 * (g - np);
    endfunction

    function automatic int field_base(input int aw, input int g);
        int np;
        np = num_pair_fields(aw);
        return (g < np) ? 4 * g : 4 * np + 8 * (g - np);
    endfunction

    function automatic int total_lines(input int aw);
        return 4 * num_pair_fields(aw) + 8 * num_triple_fields(aw);
    endfunction

    function automatic int field_weight(input int aw, input int g);
        int w;
        w = 1;
        for (int h = g + 1; h < num_fields(aw); h++)
            w = w * field_lines(aw, h);
        return w;
    endfunction

    function automatic int row_digit(input int aw, input int row, input int g);
        return (row / field_weight(aw, g)) % field_lines(aw, g);
    endfunction

endpackage

// File: rtl/hdec_predec.sv
module hdec_predec #(
    parameter int IN_W = 2
) (
    input  logic [IN_W-1:0]      sel,
    output logic [(1<<IN_W)-1:0] lines
);
    localparam int LINES = 1 << IN_W;

    always_comb begin
        for (int m = 0; m < LINES; m++)
            lines[m] = (sel == IN_W'(m));
    end

    always_comb begin
        if (!$isunknown(sel)) begin
            AST_PRE_ONEHOT: assert ($onehot(lines)); // R4
        end
    end
endmodule

// File: rtl/hdec_row_gate.sv
module hdec_row_gate #(
    parameter int NIN = 2
) (
    input  logic           gate_en,
    input  logic [NIN-1:0] picks,
    output logic           wl
);
    logic nand_n;

    always_comb begin
        nand_n = ~(&{gate_en, picks});
        wl     = ~nand_n;
    end
endmodule

// File: rtl/hdec_row_decoder.sv
module hdec_row_decoder #(
    parameter int ADDR_W = 6
) (
    input  logic                   row_en,
    input  logic [ADDR_W-1:0]      addr,
    output logic [(1<<ADDR_W)-1:0] row_sel
);
    import hdec_pkg::*;

    localparam int ROWS    = 1 << ADDR_W;
    localparam int NFIELDS = num_fields(ADDR_W);
    localparam int NLINES  = total_lines(ADDR_W);

    if (ADDR_W < 4 || ADDR_W > 9) begin : g_bad_width
        $error("hdec_row_decoder: ADDR_W must lie in 4..9");
    end

    logic [NLINES-1:0] pre_bus;

    for (genvar g = 0; g < NFIELDS; g++) begin : g_field
        localparam int FB  = field_bits(ADDR_W, g);
        localparam int LSB = field_lsb(ADDR_W, g);
        localparam int OFF = field_base(ADDR_W, g);
        hdec_predec #(.IN_W(FB)) u_pre (
            .sel   (addr[LSB +: FB]),
            .lines (pre_bus[OFF +: (1 << FB)])
        );
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [NFIELDS-1:0] picks;
        for (genvar g = 0; g < NFIELDS; g++) begin : g_pick
            localparam int LINE = field_base(ADDR_W, g) + row_digit(ADDR_W, r, g);
            assign picks[g] = pre_bus[LINE];
        end
        hdec_row_gate #(.NIN(NFIELDS)) u_gate (
            .gate_en (row_en),
            .picks   (picks),
            .wl      (row_sel[r])
        );
    end

    always_comb begin
        if (!$isunknown({row_en, addr})) begin
            AST_PRE_PER_FIELD: assert ($countones(pre_bus) == NFIELDS); // R2
            AST_DISABLED_QUIET: assert (row_en || (row_sel == '0)); // R8
            AST_ONE_ROW: assert (!row_en || $onehot(row_sel)); // R7
        end
    end
endmodule

// File: tb/hdec_row_decoder_tb_top.sv
module hdec_row_decoder_tb_top;
    logic       clk = 1'b0;
    logic       row_en;
    logic [8:0] addr;
    logic [511:0] dec_all [4:9];
    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    for (genvar W = 4; W <= 9; W++) begin : g_w
        logic [(1<<W)-1:0] sel_w;
        hdec_row_decoder #(.ADDR_W(W)) dut_i (
            .row_en  (row_en),
            .addr    (addr[W-1:0]),
            .row_sel (sel_w)
        );
        assign dec_all[W] = 512'(sel_w);
    end

    function automatic int model_row(input int w, input int a);
        int np, nt, row, pos;
        case (w)
            4: begin np = 2; nt = 0; end
            5: begin np = 1; nt = 1; end
            6: begin np = 3; nt = 0; end
            7: begin np = 2; nt = 1; end
            8: begin np = 1; nt = 2; end
            default: begin np = 0; nt = 3; end
        endcase
        row = 0;
        pos = 0;
        for (int g = 0; g < np; g++) begin
            row = row * 4 + ((a >> pos) & 3);
            pos += 2;
        end
        for (int g = 0; g < nt; g++) begin
            row = row * 8 + ((a >> pos) & 7);
            pos += 3;
        end
        return row;
    endfunction

    task automatic apply(input bit en, input int a);
        @(posedge clk);
        row_en = en;
        addr   = 9'(a);
        @(negedge clk);
    endtask

    task automatic check_eq(input int w, input logic [511:0] exp_v, input string tag);
        n_checks++;
        if (dec_all[w] !== exp_v) begin
            n_fail++;
            $display("FAIL %s width=%0d addr=%0h actual=%0h expected=%0h",
                     tag, w, addr, dec_all[w], exp_v);
        end
    endtask

    task automatic directed(input int w, input int a, input int exp_row, input string tag);
        apply(1'b1, a);
        check_eq(w, 512'(1) << exp_row, tag);
    endtask

    initial begin
        int seed;
        row_en = 1'b0;
        addr   = '0;
        seed   = $urandom(32'd2718);

        apply(1'b0, 0);
        for (int w = 4; w <= 9; w++) check_eq(w, '0, "R8 disabled at start");

        for (int w = 4; w <= 9; w++) begin
            directed(w, 0, 0, "R1 zero address");
            directed(w, (1 << w) - 1, (1 << w) - 1, "R1 all-ones address");
        end
        directed(4, 4'b0010, 8, "R4 field0 value 2");
        directed(4, 4'b0100, 1, "R5 field1 weight");
        directed(5, 5'b10000, 4, "R3 triple after pair");
        directed(5, 5'b00011, 24, "R5 field0 weight");
        directed(6, 6'b000001, 16, "R6 field0 weight");
        directed(6, 6'b010000, 1, "R6 field2 weight");
        directed(7, 7'b0010000, 1, "R2 mix of width 7");
        directed(8, 8'b00000100, 8, "R3 first triple at bit 2");
        directed(9, 9'b000001000, 8, "R2 mix of width 9");
        directed(9, 9'b000000110, 384, "R4 field0 value 6");

        for (int w = 4; w <= 9; w++) begin
            for (int a = 0; a < (1 << w); a++) begin
                apply(1'b1, a);
                check_eq(w, 512'(1) << model_row(w, a), (w < 6) ? "R5 sweep" : "R6 sweep");
                n_checks++;
                if ($countones(dec_all[w]) != 1) begin
                    n_fail++;
                    $display("FAIL R7 width=%0d addr=%0h actual ones=%0d expected=1",
                             w, a, $countones(dec_all[w]));
                end
            end
        end

        for (int t = 0; t < 300; t++) begin
            bit en;
            int a;
            en = 1'($urandom);
            a  = int'($urandom % 512);
            apply(en, a);
            for (int w = 4; w <= 9; w++) begin
                if (en) check_eq(w, 512'(1) << model_row(w, a & ((1 << w) - 1)), "R7 random");
                else    check_eq(w, '0, "R8 random disabled");
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule